// File: doc/BRIEF.md
# FPGA Configuration Loader Sequencer

This block is the master side of a configuration link to a downstream FPGA. After a start command it pulses the device's program-reset line and waits for the device to report that it has cleared its configuration memory. It then streams a configuration image into the device, takes it through the completion handshake, and reports whether the run passed or failed. The image arrives one byte at a time on a valid/ready stream. The byte count and the link mode are latched with the start command.

There are two link modes. The serial mode shifts each byte out one bit per device clock pulse. The parallel mode puts a whole byte on an 8-bit bus per pulse, with chip-select and write-enable held active while the image is loaded. In parallel mode an optional busy input from the device can stall the stream. Once the image has been sent, the block keeps clocking all-ones filler until the device raises its done line with its init line high. It then gives eight more filler pulses and declares success.

Every wait has its own timeout in clock cycles, set by a parameter. Any failure returns the device pins to their inactive levels and reports a 3-bit error code.

Top module: `cfg_loader`

## Requirements
- R1: Out of reset and whenever idle, `dev_prog_no`, `dev_sel_no` and `dev_wr_no` are high, and `busy_o`, `done_ok_o`, `fail_o`, `s_ready_o` are low with `err_o` = 0.
- R2: After `start_i`, `dev_prog_no` is held low for at least PROG_LOW_CYC cycles. It is released only once `dev_init_ni` is low. If `dev_init_ni` is not low within INIT_TMO_CYC cycles, the run fails with `err_o` = 1.
- R3: After release, the block waits for `dev_init_ni` high (and, in parallel mode with busy checking, for `dev_busy_i` low) before loading. If this does not happen within INIT_TMO_CYC cycles, the run fails with `err_o` = 2.
- R4: Serial mode (`par_mode_i` = 0): each byte goes out most significant bit first on `dev_data_o[0]`, with one `dev_clk_o` pulse per bit and the data stable in the cycle the pulse rises. Chip-select and write-enable stay high.
- R5: Parallel mode (`par_mode_i` = 1): each byte is driven on `dev_data_o` with one `dev_clk_o` pulse. `dev_sel_no` and `dev_wr_no` are low for every image byte and high again before any filler pulse.
- R6: In parallel mode, the next byte waits while `dev_busy_i` is high. If busy stays high for BUSY_TMO_CYC cycles, the run fails with `err_o` = 3.
- R7: If `dev_init_ni` is low when the next image byte is due, the run fails with `err_o` = 4, and `fail_ofs_o` gives the number of image bytes accepted.
- R8: If `dev_done_i` rises before the whole image is sent, no further bytes are accepted and the block moves to the completion phase.
- R9: In the completion phase, filler is all ones (8 bits serial, one 0xFF byte parallel). Once `dev_done_i` and `dev_init_ni` are both high, exactly 8 further `dev_clk_o` pulses are issued, then `done_ok_o` rises.
- R10: If `dev_done_i` and `dev_init_ni` are not both high within DONE_TMO_CYC cycles of the completion phase starting, the run fails with `err_o` = 5.
- R11: After any failure the pins return to inactive levels and the block is idle with `fail_o` high. A new start repeats the whole sequence from the program-reset pulse.
- R12: Exactly `len_i` bytes are accepted through `s_valid_i`/`s_ready_o` on a full run, even if more are offered. `s_ready_o` is never high while `dev_init_ni` is low or `dev_done_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a configuration run (taken when idle) |
| par_mode_i | input | 1 | 0 = serial link, 1 = 8-bit parallel link; latched at start |
| len_i | input | LEN_W | Image length in bytes; latched at start |
| s_valid_i | input | 1 | Image byte valid |
| s_data_i | input | DW | Image byte |
| s_ready_o | output | 1 | Image byte accepted when high with `s_valid_i` |
| dev_prog_no | output | 1 | Device program-reset, active low |
| dev_init_ni | input | 1 | Device init status, low while clearing or on error |
| dev_done_i | input | 1 | Device configuration done |
| dev_busy_i | input | 1 | Device busy (parallel mode) |
| dev_clk_o | output | 1 | Configuration clock, one-cycle high pulses |
| dev_data_o | output | DW | Configuration data; bit 0 carries serial data |
| dev_sel_no | output | 1 | Chip-select, active low |
| dev_wr_no | output | 1 | Write-enable, active low |
| busy_o | output | 1 | A run is in progress |
| done_ok_o | output | 1 | Last run passed; held until next start |
| fail_o | output | 1 | Last run failed; held until next start |
| err_o | output | 3 | Failure cause: 1 init-assert, 2 init-release, 3 busy, 4 CRC, 5 done timeout |
| fail_ofs_o | output | LEN_W | Image bytes accepted when the run failed |

## Verification
The bench attaches a behavioural device model. That model rebuilds serial bytes from the data bit at each clock rise, checks that the bit order is MSB first, and checks that filler is all ones. A wrong shift direction, or a missing pulse, garbles the rebuilt bytes. The model raises done at a set pulse count and counts the pulses that follow. A controller that counts filler in bytes, or that starts counting one cycle early or late, gives a count other than eight. Other cases stop the run early: init dropping after two bytes must report offset 2 and not 3, busy held high must trip the busy timeout, and done arriving after one byte must shut off the stream. Surplus bytes are offered and must stay unaccepted. After every abort the bench checks that the pins are inactive and that a fresh start runs to completion again.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_REL, ST_LOAD, ST_FILL
  } st_e;

  typedef enum logic [2:0] {
    E_NONE     = 3'd0,
    E_INIT_SET = 3'd1,
    E_INIT_REL = 3'd2,
    E_BUSY     = 3'd3,
    E_CRC      = 3'd4,
    E_DONE     = 3'd5
  } err_e;

  localparam int unsigned XTRA_PULSES = 8;
endpackage

// File: rtl/cfg_tmo.sv
// Counts while run_i is high; exp_o once LIMIT cycles have elapsed.
module cfg_tmo #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic exp_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign exp_o = run_i && (cnt_q == LIM);
endmodule

// File: rtl/cfg_shift.sv
// One unit = DW serial bits or one parallel word; each bit is a low then high clock phase.
module cfg_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic          par_i,
  input  logic [DW-1:0] word_i,
  output logic          idle_o,
  output logic          dclk_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned BW = $clog2(DW + 1);

  logic [DW-1:0] sh_q;
  logic [BW-1:0] left_q;
  logic          ph_q, dclk_q, par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; left_q <= '0; ph_q <= 1'b0; dclk_q <= 1'b0; par_q <= 1'b0;
    end else if (clr_i) begin
      left_q <= '0; ph_q <= 1'b0; dclk_q <= 1'b0;
    end else if (ld_i) begin
      sh_q   <= word_i;
      par_q  <= par_i;
      left_q <= par_i ? BW'(1) : BW'(DW);
      ph_q   <= 1'b0;
      dclk_q <= 1'b0;
    end else if (left_q != '0) begin
      if (!ph_q) begin
        ph_q   <= 1'b1;
        dclk_q <= 1'b1;
      end else begin
        ph_q   <= 1'b0;
        dclk_q <= 1'b0;
        left_q <= left_q - 1'b1;
        if (!par_q) sh_q <= {sh_q[DW-2:0], 1'b1};
      end
    end
  end

  assign idle_o = (left_q == '0);
  assign dclk_o = dclk_q;
  assign data_o = par_q ? sh_q : {{(DW-1){1'b0}}, sh_q[DW-1]};
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DW           = 8,
  parameter int unsigned LEN_W        = 24,
  parameter int unsigned PROG_LOW_CYC = 30,
  parameter int unsigned INIT_TMO_CYC = 50_000_000,
  parameter int unsigned BUSY_TMO_CYC = 500_000,
  parameter int unsigned DONE_TMO_CYC = 20_000_000,
  parameter bit          BUSY_CHECK   = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             par_mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             s_ready_o,
  output logic             dev_prog_no,
  input  logic             dev_init_ni,
  input  logic             dev_done_i,
  input  logic             dev_busy_i,
  output logic             dev_clk_o,
  output logic [DW-1:0]    dev_data_o,
  output logic             dev_sel_no,
  output logic             dev_wr_no,
  output logic             busy_o,
  output logic             done_ok_o,
  output logic             fail_o,
  output logic [2:0]       err_o,
  output logic [LEN_W-1:0] fail_ofs_o
);
  localparam int unsigned XW = $clog2(XTRA_PULSES);
  localparam logic [XW-1:0] XLAST = XW'(XTRA_PULSES - 1);

  st_e              st_q, st_d;
  err_e             err_q, err_d;
  logic             ok_d, ok_q, fail_q, par_q, seen_q;
  logic [LEN_W-1:0] len_q, sent_q, ofs_q;
  logic [XW-1:0]    xtra_q;
  logic             hold_exp, ia_exp, ir_exp, bz_exp, dn_exp;
  logic             drv_idle, drv_clk, drv_ld, bz_wait, last_b, take;
  logic [DW-1:0]    drv_word;

  assign last_b  = (sent_q == len_q);
  assign bz_wait = BUSY_CHECK && (st_q == ST_LOAD) && drv_idle && par_q && dev_busy_i;
  assign s_ready_o = (st_q == ST_LOAD) && drv_idle && !bz_wait && !last_b
                     && !dev_done_i && dev_init_ni;
  assign take     = s_ready_o && s_valid_i;
  assign drv_ld   = take || ((st_q == ST_FILL) && drv_idle);
  assign drv_word = take ? s_data_i : '1;

  cfg_tmo #(.LIMIT(PROG_LOW_CYC)) u_hold (.clk_i, .rst_ni, .run_i(st_q == ST_PROG), .exp_o(hold_exp));
  cfg_tmo #(.LIMIT(INIT_TMO_CYC)) u_ia   (.clk_i, .rst_ni, .run_i(st_q == ST_PROG), .exp_o(ia_exp));
  cfg_tmo #(.LIMIT(INIT_TMO_CYC)) u_ir   (.clk_i, .rst_ni, .run_i(st_q == ST_REL),  .exp_o(ir_exp));
  cfg_tmo #(.LIMIT(BUSY_TMO_CYC)) u_bz   (.clk_i, .rst_ni, .run_i(bz_wait),         .exp_o(bz_exp));
  cfg_tmo #(.LIMIT(DONE_TMO_CYC)) u_dn   (.clk_i, .rst_ni, .run_i((st_q == ST_FILL) && !seen_q),
                                          .exp_o(dn_exp));

  cfg_shift #(.DW(DW)) u_drv (
    .clk_i, .rst_ni,
    .clr_i (st_q == ST_IDLE),
    .ld_i  (drv_ld),
    .par_i (par_q),
    .word_i(drv_word),
    .idle_o(drv_idle),
    .dclk_o(drv_clk),
    .data_o(dev_data_o)
  );

  always_comb begin
    st_d  = st_q;
    err_d = E_NONE;
    ok_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_PROG;
      ST_PROG:
        if (hold_exp && !dev_init_ni) st_d = ST_REL;
        else if (ia_exp) begin st_d = ST_IDLE; err_d = E_INIT_SET; end
      ST_REL:
        if (dev_init_ni && !(BUSY_CHECK && par_q && dev_busy_i)) st_d = ST_LOAD;
        else if (ir_exp) begin st_d = ST_IDLE; err_d = E_INIT_REL; end
      ST_LOAD:
        if (drv_idle) begin
          if (bz_wait) begin
            if (bz_exp) begin st_d = ST_IDLE; err_d = E_BUSY; end
          end else if (last_b || dev_done_i) st_d = ST_FILL;
          else if (!dev_init_ni) begin st_d = ST_IDLE; err_d = E_CRC; end
        end
      ST_FILL:
        if (seen_q && drv_clk && (xtra_q == XLAST)) begin st_d = ST_IDLE; ok_d = 1'b1; end
        else if (dn_exp) begin st_d = ST_IDLE; err_d = E_DONE; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; err_q <= E_NONE; ok_q <= 1'b0; fail_q <= 1'b0; par_q <= 1'b0;
      seen_q <= 1'b0; len_q <= '0; sent_q <= '0; ofs_q <= '0; xtra_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        par_q <= par_mode_i; len_q <= len_i; sent_q <= '0; seen_q <= 1'b0; xtra_q <= '0;
        ok_q <= 1'b0; fail_q <= 1'b0; err_q <= E_NONE; ofs_q <= '0;
      end
      if (take) sent_q <= sent_q + 1'b1;
      if (st_q == ST_FILL && dev_done_i && dev_init_ni) seen_q <= 1'b1;
      if (st_q == ST_FILL && seen_q && drv_clk) xtra_q <= xtra_q + 1'b1;
      if (st_q != ST_IDLE && st_d == ST_IDLE) begin
        ok_q   <= ok_d;
        fail_q <= (err_d != E_NONE);
        err_q  <= err_d;
        if (err_d != E_NONE) ofs_q <= sent_q;
      end
    end
  end

  assign dev_prog_no = (st_q != ST_PROG);
  assign dev_sel_no  = !((st_q == ST_LOAD) && par_q);
  assign dev_wr_no   = !((st_q == ST_LOAD) && par_q);
  assign dev_clk_o   = drv_clk;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_ok_o   = ok_q;
  assign fail_o      = fail_q;
  assign err_o       = err_q;
  assign fail_ofs_o  = ofs_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int unsigned DW           = 8,
  parameter int unsigned PROG_LOW_CYC = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          s_ready_o,
  input logic          dev_prog_no,
  input logic          dev_init_ni,
  input logic          dev_done_i,
  input logic          dev_clk_o,
  input logic [DW-1:0] dev_data_o,
  input logic          dev_sel_no,
  input logic          dev_wr_no,
  input logic          busy_o,
  input logic          done_ok_o,
  input logic          fail_o,
  input logic [2:0]    err_o
);
  localparam int unsigned LW = $clog2(PROG_LOW_CYC + 2);
  localparam logic [LW-1:0] LMAX = LW'(PROG_LOW_CYC + 1);
  localparam logic [LW-1:0] LMIN = LW'(PROG_LOW_CYC);

  logic [LW-1:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           low_cnt <= '0;
    else if (dev_prog_no)  low_cnt <= '0;
    else if (low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;
  end

  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dev_prog_no && dev_sel_no && dev_wr_no));

  assert_prog_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_prog_no) |-> (low_cnt >= LMIN));

  assert_clk_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_clk_o |=> !dev_clk_o);

  assert_data_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_clk_o) |-> $stable(dev_data_o));

  assert_sel_after_prog_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_sel_no |-> (dev_prog_no && !dev_wr_no));

  assert_ready_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (dev_init_ni && !dev_done_i && busy_o));

  assert_result_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_ok_o && fail_o));

  assert_err_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o |-> (err_o != 3'd0)) and (done_ok_o |-> (err_o == 3'd0)));
endmodule

bind cfg_loader cfg_loader_chk #(.DW(DW), .PROG_LOW_CYC(PROG_LOW_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_ready_o(s_ready_o), .dev_prog_no(dev_prog_no),
  .dev_init_ni(dev_init_ni), .dev_done_i(dev_done_i), .dev_clk_o(dev_clk_o),
  .dev_data_o(dev_data_o), .dev_sel_no(dev_sel_no), .dev_wr_no(dev_wr_no),
  .busy_o(busy_o), .done_ok_o(done_ok_o), .fail_o(fail_o), .err_o(err_o)
);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam int PLOW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, par_mode_i = 1'b0;
  logic [7:0] len_i = '0;
  logic s_valid_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_ready_o, dev_prog_no, dev_clk_o, dev_sel_no, dev_wr_no;
  logic busy_o, done_ok_o, fail_o;
  logic [7:0] dev_data_o, fail_ofs_o;
  logic [2:0] err_o;
  logic init_r = 1'b1, done_r = 1'b0, busy_r = 1'b0;

  always #5 clk_i = ~clk_i;

  cfg_loader #(.DW(8), .LEN_W(8), .PROG_LOW_CYC(PLOW), .INIT_TMO_CYC(40),
               .BUSY_TMO_CYC(20), .DONE_TMO_CYC(300), .BUSY_CHECK(1'b1)) u0 (
    .clk_i, .rst_ni, .start_i, .par_mode_i, .len_i, .s_valid_i, .s_data_i, .s_ready_o,
    .dev_prog_no, .dev_init_ni(init_r), .dev_done_i(done_r), .dev_busy_i(busy_r),
    .dev_clk_o, .dev_data_o, .dev_sel_no, .dev_wr_no,
    .busy_o, .done_ok_o, .fail_o, .err_o, .fail_ofs_o);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model knobs
  bit m_par = 0, m_init_drop = 1, m_init_rise = 1;
  int m_crc_after = -1, m_done_after = -1, m_busy_hold = 0;
  // device model observations
  int rises = 0, ncap = 0, bit_n = 0, sel_rises = 0, ff_bad = 0, done_rise = -1;
  int rel_cnt = 0, bz_cnt = 0;
  bit was_low = 0, clk_prev = 0;
  logic [7:0] bit_acc = '0;
  logic [7:0] cap [0:63];

  always @(negedge clk_i) begin
    if (!dev_prog_no) begin
      if (m_init_drop) init_r = 1'b0;
      done_r = 0; busy_r = 0; bz_cnt = 0; rises = 0; ncap = 0; bit_n = 0;
      sel_rises = 0; ff_bad = 0; done_rise = -1; rel_cnt = 0; was_low = 1;
    end else begin
      if (was_low) begin rel_cnt = 3; was_low = 0; end
      else if (rel_cnt > 0) begin
        rel_cnt--;
        if (rel_cnt == 0 && m_init_rise) init_r = 1'b1;
      end
      if (dev_clk_o && !clk_prev) begin
        rises++;
        if (!dev_sel_no) begin
          if (ncap < 64) cap[ncap] = dev_data_o;
          ncap++; sel_rises++; bz_cnt = m_busy_hold;
        end else if (m_par) begin
          if (dev_data_o != 8'hFF) ff_bad++;
        end else begin
          bit_acc = {bit_acc[6:0], dev_data_o[0]};
          bit_n++;
          if (bit_n == 8) begin
            if (ncap < 64) cap[ncap] = bit_acc;
            ncap++; bit_n = 0;
          end
        end
        if (m_done_after >= 0 && rises >= m_done_after && !done_r) begin
          done_r = 1'b1; done_rise = rises;
        end
      end
      if (m_crc_after >= 0 && ncap >= m_crc_after) init_r = 1'b0;
      busy_r = (bz_cnt > 0);
      if (bz_cnt > 0) bz_cnt--;
    end
    clk_prev = dev_clk_o;
  end

  // image feeder
  logic [7:0] feed_mem [0:15];
  int feed_n = 0, feed_idx = 0;
  bit hs = 0;
  always @(negedge clk_i) begin
    #1;
    if (hs) feed_idx++;
    s_valid_i = (feed_idx < feed_n);
    s_data_i  = (feed_idx < feed_n) ? feed_mem[feed_idx] : 8'h00;
    hs = s_valid_i && s_ready_o;
  end

  int plow = 0;

  task automatic run(input bit par, input int len, input int nfeed);
    m_par = par;
    feed_idx = 0; hs = 0; feed_n = nfeed;
    @(negedge clk_i);
    start_i = 1; par_mode_i = par; len_i = 8'(len);
    @(negedge clk_i);
    start_i = 0;
    plow = 0;
    for (int i = 0; i < 5000 && busy_o; i++) begin
      @(negedge clk_i);
      if (!dev_prog_no) plow++;
    end
    @(negedge clk_i);
    feed_n = 0;
  endtask

  task automatic knobs(input bit drop, input bit rise, input int crc, input int done_at, input int bz);
    m_init_drop = drop; m_init_rise = rise; m_crc_after = crc;
    m_done_after = done_at; m_busy_hold = bz;
  endtask

  task automatic pins_idle(input string req);
    chk({req, " prog high"}, dev_prog_no, 1);
    chk({req, " sel high"}, dev_sel_no, 1);
    chk({req, " wr high"}, dev_wr_no, 1);
    chk({req, " busy low"}, busy_o, 0);
  endtask

  task automatic t_reset;
    pins_idle("R1");
    chk("R1 done_ok", done_ok_o, 0);
    chk("R1 fail", fail_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 ready", s_ready_o, 0);
  endtask

  task automatic t_serial_pass(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                               input string tag);
    feed_mem[0] = b0; feed_mem[1] = b1; feed_mem[2] = b2; feed_mem[3] = 8'h11; feed_mem[4] = 8'h22;
    knobs(1, 1, -1, 24 + 16, 0);
    run(0, 3, 5);
    chk({tag, " R2 prog low min"}, int'(plow >= PLOW && plow <= PLOW + 1), 1);
    chk({tag, " R4 byte0"}, cap[0], b0);
    chk({tag, " R4 byte1"}, cap[1], b1);
    chk({tag, " R4 byte2"}, cap[2], b2);
    chk({tag, " R4 sel unused"}, sel_rises, 0);
    for (int k = 3; k < ncap && k < 64; k++) chk({tag, " R9 serial filler"}, cap[k], 8'hFF);
    chk({tag, " R9 extra pulses"}, rises - done_rise, 8);
    chk({tag, " R12 bytes taken"}, feed_idx, 3);
    chk({tag, " R9 done_ok"}, done_ok_o, 1);
    chk({tag, " R9 err"}, err_o, 0);
  endtask

  task automatic t_par_pass;
    feed_mem[0] = 8'h5A; feed_mem[1] = 8'hC3; feed_mem[2] = 8'h0F; feed_mem[3] = 8'h96;
    feed_mem[4] = 8'h77;
    knobs(1, 1, -1, 4 + 3, 3);
    run(1, 4, 5);
    chk("R5 words", sel_rises, 4);
    chk("R5 w0", cap[0], 8'h5A);
    chk("R5 w1", cap[1], 8'hC3);
    chk("R5 w2", cap[2], 8'h0F);
    chk("R5 w3", cap[3], 8'h96);
    chk("R9 par filler", ff_bad, 0);
    chk("R9 par extra", rises - done_rise, 8);
    chk("R6 busy short ok", done_ok_o, 1);
    chk("R12 par taken", feed_idx, 4);
  endtask

  task automatic t_early_done;
    for (int k = 0; k < 4; k++) feed_mem[k] = 8'(8'h40 + k);
    knobs(1, 1, -1, 8, 0);
    run(0, 4, 4);
    chk("R8 bytes taken", feed_idx, 1);
    chk("R8 done_ok", done_ok_o, 1);
    chk("R8 extra pulses", rises - done_rise, 8);
  endtask

  task automatic t_fail(input string req, input bit par, input int len, input int exp_err,
                        input int exp_ofs);
    for (int k = 0; k < 4; k++) feed_mem[k] = 8'(8'hA0 + k);
    run(par, len, len);
    chk({req, " fail"}, fail_o, 1);
    chk({req, " err"}, err_o, exp_err);
    chk({req, " done_ok"}, done_ok_o, 0);
    if (exp_ofs >= 0) chk({req, " offset"}, fail_ofs_o, exp_ofs);
    pins_idle({req, " R11"});
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_serial_pass(8'hA5, 8'h3C, 8'h81, "ser");
    t_par_pass();
    t_early_done();
    knobs(0, 1, -1, -1, 0);  t_fail("R2", 0, 2, 1, 0);
    knobs(1, 0, -1, -1, 0);  t_fail("R3", 1, 2, 2, 0);
    knobs(1, 1, -1, -1, 1000); t_fail("R6", 1, 3, 3, 1);
    knobs(1, 1, 2, -1, 0);   t_fail("R7", 0, 4, 4, 2);
    knobs(1, 1, -1, -1, 0);  t_fail("R10", 0, 1, 5, -1);
    t_serial_pass(8'h01, 8'hFE, 8'h6B, "R11 restart");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule